// File: doc/BRIEF.md
# Interrupt Expander with Mask Registers

This block gathers sixteen peripheral interrupt lines into a single active-high, level-sensitive request to a host processor. It is meant for board glue logic. Each line passes through a two-stage synchronizer and then sets a sticky pending bit. The pending bit is set whether or not the line is enabled. The host sees its interrupt asserted while at least one pending bit has its enable set.

Software reaches the block through a small 16-bit register port with an address, a write strobe, a read strobe, write data and read data. The enable vector has no direct write. One address turns enables on for each bit written as one, and another address turns enables off for each bit written as one. Pending bits are acknowledged by writing ones to the status address. A separate address returns the synchronized live levels of the lines, with no latching or masking.

Top module: `irq_expander`

## Requirements
- R1: After reset the pending status and the enable vector are all zeros, `host_irq` is low and `rd_data` is zero.
- R2: A line that is high on a clock edge at the synchronizer output sets its pending bit. Line n maps to bit n. The bit is set whether or not the line is enabled, and it stays set after the line falls. The pending bit is readable at offset 0x16 three clock edges after the line was first sampled high.
- R3: A write to offset 0x16 clears each pending bit whose written bit is 1. Written 0 bits leave their pending bits unchanged.
- R4: If a line is setting its pending bit in the same cycle that a write to offset 0x16 clears that bit, the bit stays set.
- R5: A write to offset 0x1A sets the enable of every line whose written bit is 1. The other enables keep their values.
- R6: A write to offset 0x1C clears the enable of every line whose written bit is 1. The other enables keep their values.
- R7: A read of offset 0x1A returns the enable vector, with 1 meaning the line is enabled. A read of offset 0x1C returns the same vector and changes no state.
- R8: A read of offset 0x18 returns the line levels after the two-stage synchronizer, with no latching and no masking.
- R9: `host_irq` is high exactly when the bitwise AND of pending status and enable vector is non-zero.
- R10: Reads of any offset other than 0x16, 0x18, 0x1A or 0x1C return zero. Writes to such offsets change no state.
- R11: Writing 0xFFFF to offset 0x1C and then 0xFFFF to offset 0x16, with all lines low, leaves every enable off, every pending bit clear and `host_irq` low.
- R12: `rd_data` loads the selected register on the clock edge where `rd_en` is high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Byte offset of the register being accessed |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, registered |
| irq_lines | input | 16 | Peripheral interrupt request lines, asynchronous |
| host_irq | output | 1 | Combined active-high level interrupt |

## Verification
The assertions are checked on every cycle. They cover these behaviours:
- pending bits pick up each synchronized line level;
- a pending bit falls only under an acknowledge write that names it;
- enables move only on set or clear writes, and in the direction the written ones request;
- a cleared enable vector keeps the host interrupt low.

Some behaviours only the bench scenarios can show. These are the exact read values at each offset, the timing of raw readback through the synchronizer, the case where a set and an acknowledge of the same bit collide, the ignored unmapped offsets and the full setup sequence. A behavioural model compares `rd_data` and `host_irq` on every clock under all of this stimulus.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PEND = 2'd1,
      SEL_RAW  = 2'd2,
      SEL_ENAB = 2'd3
   } irqx_sel_e;
endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (STAGES < 2) $error("irqx_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/irqx_decode.sv
module irqx_decode
   import irqx_pkg::*;
#(
   parameter int             ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] OFS_PEND = 8'h16,
   parameter logic [ADDR_W-1:0] OFS_RAW  = 8'h18,
   parameter logic [ADDR_W-1:0] OFS_ESET = 8'h1A,
   parameter logic [ADDR_W-1:0] OFS_ECLR = 8'h1C
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   output logic              ack_wr,
   output logic              eset_wr,
   output logic              eclr_wr,
   output irqx_sel_e         rsel
);
   always_comb begin
      ack_wr  = 1'b0;
      eset_wr = 1'b0;
      eclr_wr = 1'b0;
      rsel    = SEL_NONE;
      if (addr == OFS_PEND) begin
         ack_wr = wr_en;
         rsel   = SEL_PEND;
      end else if (addr == OFS_RAW) begin
         rsel   = SEL_RAW;
      end else if (addr == OFS_ESET) begin
         eset_wr = wr_en;
         rsel    = SEL_ENAB;
      end else if (addr == OFS_ECLR) begin
         eclr_wr = wr_en;
         rsel    = SEL_ENAB;
      end
   end
endmodule

// File: rtl/irqx_core.sv
module irqx_core #(
   parameter int LINES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] raw,
   input  logic             ack_wr,
   input  logic             eset_wr,
   input  logic             eclr_wr,
   input  logic [LINES-1:0] wdata,
   output logic [LINES-1:0] pend,
   output logic [LINES-1:0] enab
);
   logic [LINES-1:0] ack_bits;

   assign ack_bits = ack_wr ? wdata : '0;

   // a request arriving in the acknowledge cycle wins over the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~ack_bits) | raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       enab <= '0;
      else if (eset_wr) enab <= enab | wdata;
      else if (eclr_wr) enab <= enab & ~wdata;
   end
endmodule

// File: rtl/irq_expander.sv
module irq_expander
   import irqx_pkg::*;
#(
   parameter int                LINES       = 16,
   parameter int                DATA_W      = 16,
   parameter int                ADDR_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] OFS_PEND    = 8'h16,
   parameter logic [ADDR_W-1:0] OFS_RAW     = 8'h18,
   parameter logic [ADDR_W-1:0] OFS_ESET    = 8'h1A,
   parameter logic [ADDR_W-1:0] OFS_ECLR    = 8'h1C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [LINES-1:0]  irq_lines,
   output logic              host_irq
);
   initial begin
      if (LINES < 1 || LINES > DATA_W)
         $error("irq_expander: LINES must be between 1 and DATA_W");
   end

   logic [LINES-1:0] raw_q;
   logic [LINES-1:0] pend_q;
   logic [LINES-1:0] enab_q;
   logic             ack_wr, eset_wr, eclr_wr;
   irqx_sel_e        rsel;
   logic [DATA_W-1:0] rd_next;

   irqx_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_lines), .q(raw_q)
   );

   irqx_decode #(
      .ADDR_W(ADDR_W), .OFS_PEND(OFS_PEND), .OFS_RAW(OFS_RAW),
      .OFS_ESET(OFS_ESET), .OFS_ECLR(OFS_ECLR)
   ) u_dec (
      .addr(addr), .wr_en(wr_en), .ack_wr(ack_wr),
      .eset_wr(eset_wr), .eclr_wr(eclr_wr), .rsel(rsel)
   );

   irqx_core #(.LINES(LINES)) u_core (
      .clk(clk), .rst_n(rst_n), .raw(raw_q), .ack_wr(ack_wr),
      .eset_wr(eset_wr), .eclr_wr(eclr_wr), .wdata(wr_data[LINES-1:0]),
      .pend(pend_q), .enab(enab_q)
   );

   always_comb begin
      rd_next = '0;
      unique case (rsel)
         SEL_PEND: rd_next[LINES-1:0] = pend_q;
         SEL_RAW:  rd_next[LINES-1:0] = raw_q;
         SEL_ENAB: rd_next[LINES-1:0] = enab_q;
         default:  rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_next;
   end

   assign host_irq = |(pend_q & enab_q);
endmodule

// File: rtl/irq_expander_chk.sv
module irq_expander_chk #(
   parameter int                LINES    = 16,
   parameter int                DATA_W   = 16,
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] OFS_PEND = 8'h16,
   parameter logic [ADDR_W-1:0] OFS_ESET = 8'h1A,
   parameter logic [ADDR_W-1:0] OFS_ECLR = 8'h1C
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [LINES-1:0]  raw_q,
   input logic [LINES-1:0]  pend_q,
   input logic [LINES-1:0]  enab_q,
   input logic              host_irq
);
   logic ck_ack, ck_eset, ck_eclr;
   assign ck_ack  = wr_en && (addr == OFS_PEND);
   assign ck_eset = wr_en && (addr == OFS_ESET);
   assign ck_eclr = wr_en && (addr == OFS_ECLR);

   p_pend_catches_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(raw_q)) == $past(raw_q)));

   p_pend_falls_only_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend_q) & ~pend_q) &
                 ~($past(ck_ack) ? $past(wr_data[LINES-1:0]) : '0)) == '0));

   p_eset_turns_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ck_eset |=> ((enab_q & $past(wr_data[LINES-1:0])) == $past(wr_data[LINES-1:0])));

   p_eclr_turns_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ck_eclr |=> ((enab_q & $past(wr_data[LINES-1:0])) == '0));

   p_enab_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ck_eset || ck_eclr) |=> $stable(enab_q));

   p_no_irq_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (enab_q == '0) |-> !host_irq);
endmodule

bind irq_expander irq_expander_chk #(
   .LINES(LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .OFS_PEND(OFS_PEND), .OFS_ESET(OFS_ESET), .OFS_ECLR(OFS_ECLR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
   .raw_q(raw_q), .pend_q(pend_q), .enab_q(enab_q), .host_irq(host_irq)
);

// File: tb/irq_expander_test.sv
`timescale 1ns/1ps
module irq_expander_test;
   localparam real CLK_PERIOD = 20.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [15:0] irq_lines = '0;
   logic        host_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_expander uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq_lines(irq_lines),
      .host_irq(host_irq)
   );

   // behavioural reference, one update per clock edge
   logic [15:0] m_d1, m_d2, m_pend, m_enab, m_rd;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_d1 <= '0; m_d2 <= '0; m_pend <= '0; m_enab <= '0; m_rd <= '0;
      end else begin
         m_d1 <= irq_lines;
         m_d2 <= m_d1;
         m_pend <= (m_pend & ~((wr_en && addr == 8'h16) ? wr_data : 16'h0)) | m_d2;
         if (wr_en && addr == 8'h1A) m_enab <= m_enab | wr_data;
         if (wr_en && addr == 8'h1C) m_enab <= m_enab & ~wr_data;
         if (rd_en) begin
            case (addr)
               8'h16:        m_rd <= m_pend;
               8'h18:        m_rd <= m_d2;
               8'h1A, 8'h1C: m_rd <= m_enab;
               default:      m_rd <= 16'h0;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // R9 and R12 against the model on every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R12 model rd_data", rd_data, m_rd);
         chk("R9 model host_irq", {15'h0, host_irq}, {15'h0, |(m_pend & m_enab)});
      end
   end

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      idle(4);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1 host_irq", {15'h0, host_irq}, 16'h0);
      chk("R1 rd_data", rd_data, 16'h0);
      rd(8'h16, v); chk("R1 pending", v, 16'h0);
      rd(8'h1A, v); chk("R1 enable", v, 16'h0);

      // R2 pulse while disabled
      irq_lines = 16'h0005; idle(1); irq_lines = '0;
      idle(3);
      rd(8'h16, v); chk("R2 pending latched", v, 16'h0005);
      chk("R9 masked no irq", {15'h0, host_irq}, 16'h0);

      // R8 raw readback
      irq_lines = 16'h8100; idle(3);
      rd(8'h18, v); chk("R8 raw levels", v, 16'h8100);
      irq_lines = '0; idle(3);
      rd(8'h18, v); chk("R8 raw low", v, 16'h0000);
      rd(8'h16, v); chk("R2 sticky", v, 16'h8105);

      // R5 enables
      wr(8'h1A, 16'h0001);
      chk("R9 irq on enable", {15'h0, host_irq}, 16'h1);
      wr(8'h1A, 16'h0100);
      rd(8'h1A, v); chk("R5 enable or", v, 16'h0101);

      // R7 read of clear address
      rd(8'h1C, v); chk("R7 clear addr read", v, 16'h0101);
      rd(8'h1A, v); chk("R7 no side effect", v, 16'h0101);

      // R3 acknowledge
      wr(8'h16, 16'h0004);
      rd(8'h16, v); chk("R3 w1c", v, 16'h8101);

      // R6 clear enable
      wr(8'h1C, 16'h0001);
      rd(8'h1A, v); chk("R6 enable clear", v, 16'h0100);
      chk("R9 still pending", {15'h0, host_irq}, 16'h1);
      wr(8'h16, 16'h0100);
      chk("R9 irq drops", {15'h0, host_irq}, 16'h0);

      // R4 set beats acknowledge
      irq_lines = 16'h0008; idle(4);
      wr(8'h16, 16'h0008);
      rd(8'h16, v); chk("R4 set wins", v & 16'h0008, 16'h0008);
      irq_lines = '0; idle(4);
      wr(8'h16, 16'h0008);
      rd(8'h16, v); chk("R3 cleared after drop", v, 16'h8001);

      // R10 unmapped offsets
      wr(8'h1E, 16'hFFFF);
      wr(8'h00, 16'hFFFF);
      rd(8'h1A, v); chk("R10 enable untouched", v, 16'h0100);
      rd(8'h16, v); chk("R10 pending untouched", v, 16'h8001);
      rd(8'h00, v); chk("R10 unmapped read", v, 16'h0000);

      // R12 hold when rd_en low
      wr(8'h1A, 16'hFFFF);
      idle(2);
      chk("R12 rd_data holds", rd_data, 16'h0000);

      // R11 setup sequence
      irq_lines = 16'hFFFF; idle(1); irq_lines = '0; idle(4);
      chk("R11 irq before", {15'h0, host_irq}, 16'h1);
      wr(8'h1C, 16'hFFFF);
      wr(8'h16, 16'hFFFF);
      chk("R11 irq low", {15'h0, host_irq}, 16'h0);
      rd(8'h1A, v); chk("R11 enable off", v, 16'h0);
      rd(8'h16, v); chk("R11 pending clear", v, 16'h0);

      idle(2);
      done = 1;
      summary();
      $finish;
   end
endmodule